// File: doc/BRIEF.md
# Dual-Channel Parallel ADC Sequencer

This block runs the host side of an external converter that samples two channels at the same instant and returns each result as a 14-bit word on a parallel bus. A one-cycle request in idle starts a transaction. The block latches which input pair to use and the output coding. It drives the pair select out and holds it for a setup time. It then pulls the active-low convert-start line low for a fixed pulse width, which starts the conversion on that falling edge. After that it waits for the converter's busy line to go high and then low again.

When busy has fallen, the block runs two read strobes on the shared, active-low chip-select and read lines. The first read returns the channel-1 word and the second returns the channel-2 word. Each word is sampled on the last cycle before its strobe is released. Both words then go through a formatter that produces signed values, and they appear together with the pair index in a single-cycle valid pulse. If busy does not complete its high-then-low cycle within a bounded number of cycles after the start edge, the block raises a one-cycle error and returns to idle. The busy input is taken as already synchronous to the block clock.

Top module: `adc_pair_seq`

## Requirements
- R1: While reset is held and right after it is released, conv_n_o, cs_n_o and rd_n_o are high, and valid_o and err_o are low.
- R2: A request is accepted only in idle. pair_sel_i and twos_i are sampled at acceptance. Changes to them, and further requests, during a transaction have no effect, and each accepted request produces exactly one convert-start falling edge.
- R3: pair_o carries the latched select (0 = first input pair, 1 = second input pair). It is stable for at least SETUP_CYC cycles before conv_n_o falls and stays unchanged while conv_n_o is low.
- R4: conv_n_o stays low for exactly CONV_LOW_CYC cycles and then returns high.
- R5: Once busy_i has been seen high and then low, exactly two read strobes follow. During each strobe cs_n_o and rd_n_o are low together for RD_LOW_CYC cycles, the two strobes are separated by at least one high cycle, and no strobe overlaps a low conv_n_o.
- R6: data_i is sampled on the last low cycle of each strobe. The first strobe supplies ch1_o and the second supplies ch2_o.
- R7: valid_o is a one-cycle pulse. In that cycle ch1_o, ch2_o and res_pair_o hold the transaction's results and pair index.
- R8: With twos_i = 1 the word is taken as two's complement and bit 13 is sign-extended to OUT_W bits (0x1FFF -> 8191, 0x2000 -> -8192).
- R9: With twos_i = 0 the word is taken as straight binary. Bit 13 is inverted and the result is sign-extended (0x0000 -> -8192, 0x3FFF -> 8191).
- R10: If busy_i has not both risen and fallen within TIMEOUT_CYC cycles of the conv_n_o falling edge, err_o pulses for one cycle, exactly TIMEOUT_CYC cycles after that edge. No valid_o pulse or read strobe follows, conv_n_o is high, and the block accepts the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a transaction (accepted in idle only) |
| pair_sel_i | input | 1 | Input pair to convert: 0 first, 1 second |
| twos_i | input | 1 | Converter coding: 1 two's complement, 0 straight binary |
| conv_n_o | output | 1 | Convert start to the converter, active low |
| pair_o | output | 1 | Pair select to the converter |
| busy_i | input | 1 | Converter busy, synchronous to clk_i |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| data_i | input | DATA_W | Converter data bus, bit 13 most significant |
| valid_o | output | 1 | One-cycle result pulse |
| res_pair_o | output | 1 | Pair index of the result |
| ch1_o | output | OUT_W | Signed channel-1 result |
| ch2_o | output | OUT_W | Signed channel-2 result |
| err_o | output | 1 | One-cycle busy timeout pulse |

## Verification
On every cycle, the assertions hold the strobe shape: the pair-select setup before the start edge, pair stability during the start pulse, the exact start and read pulse widths, no read overlapping the start pulse, and valid and error being distinct one-cycle pulses. The scenarios are the only place to see that the right data word lands in the right channel with the right coding, that both coding modes map the boundary codes correctly, that select and coding changes after acceptance are ignored, and that a missing busy rise or a stuck busy gives an error at the exact bound and the block then recovers.

// File: rtl/adc_pair_seq_pkg.sv
package adc_pair_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CONV,
    ST_WAIT,
    ST_RD1,
    ST_GAP,
    ST_RD2
  } seq_state_e;

  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
  parameter int IN_W  = 14,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  raw_i,
  input  logic             twos_i,
  output logic [OUT_W-1:0] val_o
);

  logic [IN_W-1:0] adj;

  // straight binary becomes two's complement by flipping the top bit
  assign adj = raw_i ^ {~twos_i, {(IN_W-1){1'b0}}};

  if (OUT_W > IN_W) begin : g_ext
    assign val_o = {{(OUT_W-IN_W){adj[IN_W-1]}}, adj};
  end else begin : g_trunc
    assign val_o = adj[OUT_W-1:0];
  end

endmodule

// File: rtl/adc_pair_seq.sv
module adc_pair_seq
  import adc_pair_seq_pkg::*;
#(
  parameter int DATA_W       = 14,
  parameter int OUT_W        = 16,
  parameter int SETUP_CYC    = 2,
  parameter int CONV_LOW_CYC = 2,
  parameter int RD_LOW_CYC   = 2,
  parameter int TIMEOUT_CYC  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              pair_sel_i,
  input  logic              twos_i,
  output logic              conv_n_o,
  output logic              pair_o,
  input  logic              busy_i,
  output logic              cs_n_o,
  output logic              rd_n_o,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic              res_pair_o,
  output logic [OUT_W-1:0]  ch1_o,
  output logic [OUT_W-1:0]  ch2_o,
  output logic              err_o
);

  localparam int PH_MAX_A = (SETUP_CYC > CONV_LOW_CYC) ? SETUP_CYC : CONV_LOW_CYC;
  localparam int PH_MAX   = (PH_MAX_A > RD_LOW_CYC) ? PH_MAX_A : RD_LOW_CYC;
  localparam int PH_W     = $clog2(PH_MAX + 1);
  localparam int TO_W     = $clog2(TIMEOUT_CYC + 1);

  seq_state_e state_q, state_d;
  logic conv_n_q, conv_n_d;
  logic cs_n_q, cs_n_d, rd_n_q, rd_n_d;
  logic valid_q, valid_d, err_q, err_d;
  logic pair_q, twos_q, seen_q;
  logic start, cap1, cap2;
  logic [DATA_W-1:0] raw_q [NUM_CH];
  logic [OUT_W-1:0]  res   [NUM_CH];

  logic            ph_load, ph_dec, ph_zero;
  logic [PH_W-1:0] ph_val;
  logic            to_load, to_dec, to_zero;

  adc_seq_timer #(.W(PH_W)) i_ph_timer (
    .clk_i, .rst_ni,
    .load_i(ph_load), .load_val_i(ph_val), .dec_i(ph_dec), .zero_o(ph_zero)
  );

  adc_seq_timer #(.W(TO_W)) i_to_timer (
    .clk_i, .rst_ni,
    .load_i(to_load), .load_val_i(TO_W'(TIMEOUT_CYC - 1)), .dec_i(to_dec),
    .zero_o(to_zero)
  );

  always_comb begin
    state_d  = state_q;
    conv_n_d = conv_n_q;
    cs_n_d   = cs_n_q;
    rd_n_d   = rd_n_q;
    valid_d  = 1'b0;
    err_d    = 1'b0;
    start    = 1'b0;
    cap1     = 1'b0;
    cap2     = 1'b0;
    ph_load  = 1'b0;
    ph_val   = '0;
    ph_dec   = 1'b0;
    to_load  = 1'b0;
    to_dec   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        start   = 1'b1;
        state_d = ST_SETUP;
        ph_load = 1'b1;
        ph_val  = PH_W'(SETUP_CYC - 1);
      end
      ST_SETUP: begin
        ph_dec = 1'b1;
        if (ph_zero) begin
          state_d  = ST_CONV;
          conv_n_d = 1'b0;
          ph_load  = 1'b1;
          ph_val   = PH_W'(CONV_LOW_CYC - 1);
          to_load  = 1'b1;
        end
      end
      ST_CONV: begin
        ph_dec = 1'b1;
        to_dec = 1'b1;
        if (to_zero) begin
          err_d    = 1'b1;
          conv_n_d = 1'b1;
          state_d  = ST_IDLE;
        end else if (ph_zero) begin
          conv_n_d = 1'b1;
          state_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        to_dec = 1'b1;
        if (to_zero) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (seen_q && !busy_i) begin
          state_d = ST_RD1;
          cs_n_d  = 1'b0;
          rd_n_d  = 1'b0;
          ph_load = 1'b1;
          ph_val  = PH_W'(RD_LOW_CYC - 1);
        end
      end
      ST_RD1: begin
        ph_dec = 1'b1;
        if (ph_zero) begin
          cap1    = 1'b1;
          cs_n_d  = 1'b1;
          rd_n_d  = 1'b1;
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        state_d = ST_RD2;
        cs_n_d  = 1'b0;
        rd_n_d  = 1'b0;
        ph_load = 1'b1;
        ph_val  = PH_W'(RD_LOW_CYC - 1);
      end
      ST_RD2: begin
        ph_dec = 1'b1;
        if (ph_zero) begin
          cap2    = 1'b1;
          cs_n_d  = 1'b1;
          rd_n_d  = 1'b1;
          valid_d = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      conv_n_q <= 1'b1;
      cs_n_q   <= 1'b1;
      rd_n_q   <= 1'b1;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
      pair_q   <= 1'b0;
      twos_q   <= 1'b0;
      seen_q   <= 1'b0;
      raw_q[0] <= '0;
      raw_q[1] <= '0;
    end else begin
      state_q  <= state_d;
      conv_n_q <= conv_n_d;
      cs_n_q   <= cs_n_d;
      rd_n_q   <= rd_n_d;
      valid_q  <= valid_d;
      err_q    <= err_d;
      if (start) begin
        pair_q <= pair_sel_i;
        twos_q <= twos_i;
        seen_q <= 1'b0;
      end else if ((state_q == ST_CONV || state_q == ST_WAIT) && busy_i) begin
        seen_q <= 1'b1;
      end
      if (cap1) raw_q[0] <= data_i;
      if (cap2) raw_q[1] <= data_i;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    adc_seq_fmt #(.IN_W(DATA_W), .OUT_W(OUT_W)) i_fmt (
      .raw_i(raw_q[g]), .twos_i(twos_q), .val_o(res[g])
    );
  end

  assign conv_n_o   = conv_n_q;
  assign pair_o     = pair_q;
  assign cs_n_o     = cs_n_q;
  assign rd_n_o     = rd_n_q;
  assign valid_o    = valid_q;
  assign err_o      = err_q;
  assign res_pair_o = pair_q;
  assign ch1_o      = res[0];
  assign ch2_o      = res[1];

endmodule

// File: rtl/adc_pair_seq_chk.sv
module adc_pair_seq_chk #(
  parameter int SETUP_CYC    = 2,
  parameter int CONV_LOW_CYC = 2,
  parameter int RD_LOW_CYC   = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic conv_n_o,
  input logic pair_o,
  input logic rd_n_o,
  input logic valid_o,
  input logic err_o
);

  logic [15:0] stab_q, clow_q, rlow_q;
  logic        pair_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stab_q <= '0;
      clow_q <= '0;
      rlow_q <= '0;
      pair_d <= 1'b0;
    end else begin
      pair_d <= pair_o;
      if (pair_o != pair_d)     stab_q <= '0;
      else if (stab_q != '1)    stab_q <= stab_q + 1'b1;
      clow_q <= conv_n_o ? '0 : clow_q + 1'b1;
      rlow_q <= rd_n_o   ? '0 : rlow_q + 1'b1;
    end
  end

  assert_pair_setup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(conv_n_o) |-> stab_q >= 16'(SETUP_CYC - 1));

  assert_pair_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_n_o |-> $stable(pair_o));

  assert_conv_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_n_o) |-> clow_q == 16'(CONV_LOW_CYC));

  assert_rd_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_n_o) |-> rlow_q == 16'(RD_LOW_CYC));

  assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_n_o |-> rd_n_o);

  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_err_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_err_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && valid_o));

endmodule

bind adc_pair_seq adc_pair_seq_chk #(
  .SETUP_CYC(SETUP_CYC), .CONV_LOW_CYC(CONV_LOW_CYC), .RD_LOW_CYC(RD_LOW_CYC)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .conv_n_o(conv_n_o), .pair_o(pair_o),
  .rd_n_o(rd_n_o), .valid_o(valid_o), .err_o(err_o)
);

// File: tb/test_adc_pair_seq.sv
`timescale 1ns/1ps
module test_adc_pair_seq;

  localparam int S  = 3;
  localparam int CL = 3;
  localparam int RL = 2;
  localparam int TO = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, pair_sel = 1'b0, twos = 1'b0;
  logic busy = 1'b0;
  logic [13:0] data = '0;
  logic conv_n, pair, cs_n, rd_n, valid, res_pair, err;
  logic [15:0] ch1, ch2;

  int nchk = 0, nerr = 0;

  // converter model state
  int m_kind = 0, m_blen = 3;
  logic [13:0] m_w1 = '0, m_w2 = '0;
  bit   m_active = 0;
  int   m_t = 0, conv_cnt = 0, conv_run = 0, conv_len = 0, pst = 0, setup_seen = 0;
  logic conv_prev = 1'b1, last_pair = 1'b0, pair_seen = 1'b0;
  int   rd_idx = 0, rlow = 0, rlen0 = 0, rlen1 = 0, overlap = 0;

  always #4 clk = ~clk;

  adc_pair_seq #(
    .DATA_W(14), .OUT_W(16), .SETUP_CYC(S), .CONV_LOW_CYC(CL),
    .RD_LOW_CYC(RL), .TIMEOUT_CYC(TO)
  ) i_adc_pair_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .pair_sel_i(pair_sel), .twos_i(twos),
    .conv_n_o(conv_n), .pair_o(pair), .busy_i(busy), .cs_n_o(cs_n), .rd_n_o(rd_n),
    .data_i(data), .valid_o(valid), .res_pair_o(res_pair), .ch1_o(ch1), .ch2_o(ch2),
    .err_o(err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (pair === last_pair) pst++; else pst = 1;
      last_pair = pair;
      if (conv_prev && !conv_n) begin
        conv_cnt++; m_t = 0; m_active = 1; pair_seen = pair; setup_seen = pst;
        rd_idx = 0; rlen0 = 0; rlen1 = 0; conv_run = 0;
      end else if (m_active) m_t++;
      if (!conv_n) conv_run++;
      if (conv_n && !conv_prev) conv_len = conv_run;
      conv_prev = conv_n;
      case (m_kind)
        0: busy = m_active && m_t >= 1 && m_t <= m_blen;
        1: busy = 1'b0;
        default: busy = m_active && m_t >= 1 && m_t <= TO + 5;
      endcase
      if (!cs_n && !rd_n) begin
        rlow++;
        data = (rd_idx == 0) ? m_w1 : m_w2;
      end else begin
        if (rlow > 0) begin
          if (rd_idx == 0) rlen0 = rlow; else if (rd_idx == 1) rlen1 = rlow;
          rd_idx++; rlow = 0;
        end
        data = ((rd_idx == 0) ? m_w1 : m_w2) ^ 14'h1555;
      end
      if (!conv_n && !rd_n) overlap++;
      if (rd_n != cs_n) overlap++;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int expv(input int w, input bit tw);
    if (tw) return (w >= 8192) ? w - 16384 : w;
    return w - 8192;
  endfunction

  function automatic logic [13:0] word(input int k, input int p);
    case (k)
      0: return 14'h0000;
      1: return 14'h3FFF;
      2: return 14'h2000;
      3: return 14'h1FFF;
      default: return 14'((k * 32'h1357 + p * 32'h0AB) & 32'h3FFF);
    endcase
  endfunction

  task automatic run(input bit p, input bit tw, input logic [13:0] w1, input logic [13:0] w2,
                     input int blen, input int kind);
    bit gv = 0, ge = 0;
    int n = -1, c0;
    int a1 = 0, a2 = 0, ap = 0;
    m_w1 = w1; m_w2 = w2; m_blen = blen; m_kind = kind;
    c0 = conv_cnt;
    req = 1'b1; pair_sel = p; twos = tw;
    for (int c = 0; c < 400 && !(gv || ge); c++) begin
      tick();
      if (c == 0) begin req = 1'b0; pair_sel = ~p; twos = ~tw; end
      if (c == 3) req = 1'b1;
      if (c == 4) req = 1'b0;
      if (n >= 0) n++; else if (!conv_n) n = 0;
      if (valid) begin gv = 1; a1 = int'($signed(ch1)); a2 = int'($signed(ch2)); ap = res_pair; end
      if (err) ge = 1;
    end
    if (kind == 0) begin
      chk(gv, "R7 valid seen", gv, 1);
      if (tw) begin
        chk(a1 == expv(w1, 1), "R8/R6 ch1 two's complement", a1, expv(w1, 1));
        chk(a2 == expv(w2, 1), "R8/R6 ch2 two's complement", a2, expv(w2, 1));
      end else begin
        chk(a1 == expv(w1, 0), "R9/R6 ch1 straight binary", a1, expv(w1, 0));
        chk(a2 == expv(w2, 0), "R9/R6 ch2 straight binary", a2, expv(w2, 0));
      end
      chk(ap == p, "R7 res_pair", ap, p);
      tick();
      chk(!valid, "R7 valid one cycle", valid, 0);
      tick();
      chk(conv_cnt - c0 == 1, "R2 one start per request", conv_cnt - c0, 1);
      chk(pair_seen == p, "R3 pair at start", pair_seen, p);
      chk(setup_seen >= S + 1, "R3 pair setup", setup_seen, S + 1);
      chk(conv_len == CL, "R4 start width", conv_len, CL);
      chk(rd_idx == 2, "R5 read count", rd_idx, 2);
      chk(rlen0 == RL && rlen1 == RL, "R5 read widths", rlen0 * 100 + rlen1, RL * 101);
      chk(overlap == 0, "R5 strobe overlap", overlap, 0);
    end else begin
      chk(ge, "R10 error seen", ge, 1);
      chk(n == TO, "R10 error timing", n, TO);
      chk(!gv, "R10 no valid", gv, 0);
      tick();
      chk(!err && conv_n && cs_n && rd_n, "R10 back to idle", {err, conv_n, cs_n, rd_n}, 4'b0111);
      chk(rd_idx == 0, "R10 no read", rd_idx, 0);
      repeat (TO + 8) tick();
    end
    repeat (3) tick();
  endtask

  initial begin
    #(8 * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #20;
    chk(conv_n && cs_n && rd_n && !valid && !err, "R1 reset state",
        {conv_n, cs_n, rd_n, valid, err}, 5'b11100);
    tick(); rst_n = 1'b1;
    tick(); tick();
    chk(conv_n && cs_n && rd_n && !valid && !err, "R1 after release",
        {conv_n, cs_n, rd_n, valid, err}, 5'b11100);
    for (int p = 0; p < 2; p++)
      for (int f = 0; f < 2; f++)
        for (int k = 0; k < 8; k++)
          run(p[0], f[0], word(k, p), word(7 - k, p + 2), 3 + (k % 6), 0);
    run(1'b1, 1'b1, 14'h0123, 14'h3210, 4, 1);   // R10 busy never rises
    run(1'b0, 1'b0, 14'h0456, 14'h2654, 4, 2);   // R10 busy never falls
    run(1'b1, 1'b0, 14'h3FFF, 14'h0000, 5, 0);   // recovery after error
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule